// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home-node directory logic for a single memory block in a distributed-memory multiprocessor with `NPROC` processors. It records whether the block is uncached, shared (memory is current and one or more caches hold read copies) or exclusive (one cache owns a modified copy and memory is stale). It also keeps a sharer vector with one bit per processor. Each incoming message updates the directory and produces the messages needed to satisfy the request. Invalidates and fetches go point-to-point to the caches that hold the block, and every miss gets an explicit data reply.

Misses arrive on a request channel that has a ready signal. Data write-backs arrive on a separate channel that is always accepted. Outgoing messages appear as one-cycle pulses one clock after the incoming message is taken. The pulses are: a data reply with a destination id, an invalidate with a destination mask, a fetch or fetch/invalidate with a destination id, and a memory-write strobe when write-back data is absorbed.

A miss that finds the block exclusive sends a fetch to the owner and parks the controller in a waiting state. The controller finishes the request when the owner's write-back arrives. Until then `req_ready` stays low.

The internal states are:
- `S_UNC`: uncached.
- `S_SHR`: shared.
- `S_EXC`: exclusive.
- `S_WRD`: waiting for the owner's write-back after a read miss.
- `S_WWR`: waiting for the owner's write-back after a write miss.

The transitions are:
- `S_UNC` to `S_SHR` on a read miss.
- `S_UNC` to `S_EXC` on a write miss.
- `S_SHR` to `S_SHR` on a read miss.
- `S_SHR` to `S_EXC` on a write miss.
- `S_EXC` to `S_WRD` on a read miss.
- `S_EXC` to `S_WWR` on a write miss.
- `S_EXC` to `S_UNC` on an owner write-back.
- `S_WRD` to `S_SHR` on the owner write-back.
- `S_WWR` to `S_EXC` on the owner write-back.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `dir_state` is 0 (uncached), `dir_sharers` is all zero, `req_ready` is 1 and no output pulse is active.
- R2: A read miss from P while uncached gives, one cycle later, `rep_valid` with `rep_dst`=P, `dir_sharers` = only bit P, and `dir_state` 1 (shared).
- R3: A write miss from P while uncached gives a reply to P, `dir_sharers` = only bit P, and `dir_state` 2 (exclusive).
- R4: A read miss from P while shared gives a reply to P, ORs bit P into the sharers, sends no invalidate and keeps `dir_state` 1.
- R5: A write miss from P while shared gives `inv_valid` with `inv_mask` = old sharers with bit P cleared, a reply to P, sharers = only bit P, and `dir_state` 2. No invalidate pulse is sent when that mask is empty.
- R6: A read miss while exclusive emits `fet_valid` with `fet_inv`=0 (plain fetch) and `fet_dst` = owner. `req_ready` then stays low until the owner's write-back. That write-back gives `mem_wr`, a reply to the requester, sharers = owner plus requester, and `dir_state` 1.
- R7: A write miss while exclusive emits `fet_valid` with `fet_inv`=1 (fetch/invalidate) to the owner. The owner's write-back then gives `mem_wr`, a reply to the requester, sharers = only the requester, and `dir_state` 2.
- R8: A write-back from the owner while exclusive with nothing pending gives `mem_wr`, clears the sharers, and sets `dir_state` 0.
- R9: A write-back from a processor that is not the owner, or a write-back while not exclusive, is ignored. No pulse is emitted and the state and sharers are unchanged.
- R10: When `wb_valid` is high, `req_ready` is low in that cycle. The write-back is processed first and the held request is taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Miss request accepted this cycle when valid |
| req_is_wr | input | 1 | 0 read miss, 1 write miss |
| req_src | input | ID_W | Requesting processor |
| wb_valid | input | 1 | Data write-back present (always taken) |
| wb_src | input | ID_W | Processor sending the write-back |
| rep_valid | output | 1 | Data value reply pulse |
| rep_dst | output | ID_W | Reply destination |
| inv_valid | output | 1 | Invalidate pulse |
| inv_mask | output | NPROC | Processors to invalidate |
| fet_valid | output | 1 | Fetch pulse |
| fet_inv | output | 1 | 0 fetch, 1 fetch/invalidate |
| fet_dst | output | ID_W | Current owner being fetched from |
| mem_wr | output | 1 | Write-back data written to memory |
| dir_state | output | 2 | 0 uncached, 1 shared, 2 exclusive (also while waiting) |
| dir_sharers | output | NPROC | Sharer vector |

## Verification
A wrong internal state appears at the ports on the very next message. A corrupted sharer vector changes the next invalidate mask, the fetch destination, or which write-back is honoured. A wrong state changes which message type answers the next miss. Because `dir_state` and `dir_sharers` are outputs, a bad transition is visible one cycle after the message that caused it. A stuck waiting state shows as `req_ready` held low after the owner's write-back.

// File: rtl/dir_pkg.sv
package dir_pkg;
    typedef enum logic [2:0] {
        S_UNC = 3'd0,
        S_SHR = 3'd1,
        S_EXC = 3'd2,
        S_WRD = 3'd3,
        S_WWR = 3'd4
    } dir_st_e;

    localparam logic [1:0] CODE_UNC = 2'd0;
    localparam logic [1:0] CODE_SHR = 2'd1;
    localparam logic [1:0] CODE_EXC = 2'd2;
endpackage

// File: rtl/dir_onehot_enc.sv
module dir_onehot_enc #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | W'(i);
        end
    end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NPROC = 4,
    localparam int ID_W = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_is_wr,
    input  logic [ID_W-1:0]  req_src,
    input  logic             wb_valid,
    input  logic [ID_W-1:0]  wb_src,
    output logic             rep_valid,
    output logic [ID_W-1:0]  rep_dst,
    output logic             inv_valid,
    output logic [NPROC-1:0] inv_mask,
    output logic             fet_valid,
    output logic             fet_inv,
    output logic [ID_W-1:0]  fet_dst,
    output logic             mem_wr,
    output logic [1:0]       dir_state,
    output logic [NPROC-1:0] dir_sharers
);
    localparam logic [NPROC-1:0] ONE = NPROC'(1);

    dir_st_e          st_q, st_n;
    logic [NPROC-1:0] sh_q, sh_n;
    logic [ID_W-1:0]  pend_q, pend_n;
    logic [ID_W-1:0]  owner_id;

    logic             rep_v_n, inv_v_n, fet_v_n, fet_inv_n, mem_wr_n;
    logic [ID_W-1:0]  rep_dst_n, fet_dst_n;
    logic [NPROC-1:0] inv_mask_n, req_bit, clr_mask;
    logic             req_fire, owner_wb, idle_st;

    dir_onehot_enc #(.N(NPROC)) u_owner_enc (
        .vec (sh_q),
        .idx (owner_id)
    );

    assign idle_st   = (st_q == S_UNC) || (st_q == S_SHR) || (st_q == S_EXC);
    assign req_ready = idle_st && !wb_valid;
    assign req_fire  = req_valid && req_ready;
    assign req_bit   = ONE << req_src;
    assign owner_wb  = wb_valid && sh_q[wb_src];
    assign clr_mask  = sh_q & ~req_bit;

    // next-state and message generation
    always_comb begin
        st_n       = st_q;
        sh_n       = sh_q;
        pend_n     = pend_q;
        rep_v_n    = 1'b0;
        rep_dst_n  = '0;
        inv_v_n    = 1'b0;
        inv_mask_n = '0;
        fet_v_n    = 1'b0;
        fet_inv_n  = 1'b0;
        fet_dst_n  = '0;
        mem_wr_n   = 1'b0;
        unique case (st_q)
            S_UNC: begin
                if (req_fire) begin
                    rep_v_n   = 1'b1;
                    rep_dst_n = req_src;
                    sh_n      = req_bit;
                    st_n      = req_is_wr ? S_EXC : S_SHR;
                end
            end
            S_SHR: begin
                if (req_fire) begin
                    rep_v_n   = 1'b1;
                    rep_dst_n = req_src;
                    if (req_is_wr) begin
                        inv_v_n    = |clr_mask;
                        inv_mask_n = clr_mask;
                        sh_n       = req_bit;
                        st_n       = S_EXC;
                    end else begin
                        sh_n = sh_q | req_bit;
                    end
                end
            end
            S_EXC: begin
                if (owner_wb) begin
                    mem_wr_n = 1'b1;
                    sh_n     = '0;
                    st_n     = S_UNC;
                end else if (req_fire) begin
                    fet_v_n   = 1'b1;
                    fet_inv_n = req_is_wr;
                    fet_dst_n = owner_id;
                    pend_n    = req_src;
                    st_n      = req_is_wr ? S_WWR : S_WRD;
                end
            end
            S_WRD: begin
                if (owner_wb) begin
                    mem_wr_n  = 1'b1;
                    rep_v_n   = 1'b1;
                    rep_dst_n = pend_q;
                    sh_n      = sh_q | (ONE << pend_q);
                    st_n      = S_SHR;
                end
            end
            S_WWR: begin
                if (owner_wb) begin
                    mem_wr_n  = 1'b1;
                    rep_v_n   = 1'b1;
                    rep_dst_n = pend_q;
                    sh_n      = ONE << pend_q;
                    st_n      = S_EXC;
                end
            end
            default: st_n = S_UNC;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_UNC;
            sh_q   <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_n;
            sh_q   <= sh_n;
            pend_q <= pend_n;
        end
    end

    // registered message outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_valid <= 1'b0;
            rep_dst   <= '0;
            inv_valid <= 1'b0;
            inv_mask  <= '0;
            fet_valid <= 1'b0;
            fet_inv   <= 1'b0;
            fet_dst   <= '0;
            mem_wr    <= 1'b0;
        end else begin
            rep_valid <= rep_v_n;
            rep_dst   <= rep_dst_n;
            inv_valid <= inv_v_n;
            inv_mask  <= inv_mask_n;
            fet_valid <= fet_v_n;
            fet_inv   <= fet_inv_n;
            fet_dst   <= fet_dst_n;
            mem_wr    <= mem_wr_n;
        end
    end

    always_comb begin
        unique case (st_q)
            S_UNC:               dir_state = CODE_UNC;
            S_SHR:               dir_state = CODE_SHR;
            S_EXC, S_WRD, S_WWR: dir_state = CODE_EXC;
            default:             dir_state = CODE_UNC;
        endcase
    end
    assign dir_sharers = sh_q;

    // assertions
    assert_unc_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_UNC) |-> (sh_q == '0));

    assert_unc_read_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !req_is_wr && st_q == S_UNC) |=>
            (rep_valid && rep_dst == $past(req_src) && dir_state == CODE_SHR));

    assert_shared_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SHR) |-> (sh_q != '0));

    assert_inv_excludes_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (rep_valid && !inv_mask[rep_dst] && inv_mask != '0));

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXC || st_q == S_WRD || st_q == S_WWR) |-> ($countones(sh_q) == 1));

    assert_wait_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WRD || st_q == S_WWR) |-> !req_ready);

    assert_fetch_to_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fet_valid |-> sh_q[fet_dst]);

    assert_wb_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !req_ready);
endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
    localparam int NPROC = 4;
    localparam int ID_W  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_is_wr = 1'b0, wb_valid = 1'b0;
    logic [ID_W-1:0]  req_src = '0, wb_src = '0;
    logic             req_ready, rep_valid, inv_valid, fet_valid, fet_inv, mem_wr;
    logic [ID_W-1:0]  rep_dst, fet_dst;
    logic [NPROC-1:0] inv_mask, dir_sharers;
    logic [1:0]       dir_state;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    dir_home_ctrl #(.NPROC(NPROC)) u_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_wr(req_is_wr), .req_src(req_src),
        .wb_valid(wb_valid), .wb_src(wb_src),
        .rep_valid(rep_valid), .rep_dst(rep_dst),
        .inv_valid(inv_valid), .inv_mask(inv_mask),
        .fet_valid(fet_valid), .fet_inv(fet_inv), .fet_dst(fet_dst),
        .mem_wr(mem_wr), .dir_state(dir_state), .dir_sharers(dir_sharers)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // one cycle of stimulus; outputs sampled 1ns after the capturing edge
    task automatic step(input logic rv, input logic rw, input int rs,
                        input logic wv, input int ws);
        @(negedge clk);
        req_valid = rv; req_is_wr = rw; req_src = ID_W'(rs);
        wb_valid = wv; wb_src = ID_W'(ws);
        @(posedge clk);
        #1;
        @(negedge clk);
        req_valid = 1'b0; wb_valid = 1'b0;
    endtask

    task automatic step_sample(input logic rv, input logic rw, input int rs,
                               input logic wv, input int ws);
        @(negedge clk);
        req_valid = rv; req_is_wr = rw; req_src = ID_W'(rs);
        wb_valid = wv; wb_src = ID_W'(ws);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; wb_valid = 1'b0;
    endtask

    task automatic expect_msgs(input string tag, input int rv, input int rd, input int iv,
                               input int im, input int fv, input int fi, input int fd,
                               input int mw, input int st, input int sh);
        check({tag, " rep_valid"}, int'(rep_valid), rv);
        if (rv != 0) check({tag, " rep_dst"}, int'(rep_dst), rd);
        check({tag, " inv_valid"}, int'(inv_valid), iv);
        if (iv != 0) check({tag, " inv_mask"}, int'(inv_mask), im);
        check({tag, " fet_valid"}, int'(fet_valid), fv);
        if (fv != 0) begin
            check({tag, " fet_inv"}, int'(fet_inv), fi);
            check({tag, " fet_dst"}, int'(fet_dst), fd);
        end
        check({tag, " mem_wr"}, int'(mem_wr), mw);
        check({tag, " dir_state"}, int'(dir_state), st);
        check({tag, " dir_sharers"}, int'(dir_sharers), sh);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_msgs("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R1 ready", int'(req_ready), 1);
    endtask

    task automatic t_unc_read();
        step_sample(1, 0, 1, 0, 0);
        expect_msgs("R2 unc read", 1, 1, 0, 0, 0, 0, 0, 0, 1, 4'b0010);
        idle();
    endtask

    task automatic t_shr_read();
        step_sample(1, 0, 3, 0, 0);
        expect_msgs("R4 shr read", 1, 3, 0, 0, 0, 0, 0, 0, 1, 4'b1010);
        idle();
    endtask

    task automatic t_shr_write();
        step_sample(1, 1, 1, 0, 0);
        expect_msgs("R5 shr write", 1, 1, 1, 4'b1000, 0, 0, 0, 0, 2, 4'b0010);
        idle();
    endtask

    task automatic t_ignored_wb();
        step_sample(0, 0, 0, 1, 2);
        expect_msgs("R9 nonowner wb", 0, 0, 0, 0, 0, 0, 0, 0, 2, 4'b0010);
        idle();
    endtask

    task automatic t_exc_read();
        step_sample(1, 0, 0, 0, 0);
        expect_msgs("R6 fetch", 0, 0, 0, 0, 1, 0, 1, 0, 2, 4'b0010);
        idle();
        #1;
        check("R6 ready low while waiting", int'(req_ready), 0);
        step_sample(1, 1, 2, 0, 0);
        expect_msgs("R6 blocked req", 0, 0, 0, 0, 0, 0, 0, 0, 2, 4'b0010);
        idle();
        step_sample(0, 0, 0, 1, 1);
        expect_msgs("R6 wb done", 1, 0, 0, 0, 0, 0, 0, 1, 1, 4'b0011);
        idle();
        #1;
        check("R6 ready restored", int'(req_ready), 1);
    endtask

    task automatic t_shr_write2();
        step_sample(1, 1, 2, 0, 0);
        expect_msgs("R5 shr write multi", 1, 2, 1, 4'b0011, 0, 0, 0, 0, 2, 4'b0100);
        idle();
    endtask

    task automatic t_exc_write();
        step_sample(1, 1, 3, 0, 0);
        expect_msgs("R7 fetch-inv", 0, 0, 0, 0, 1, 1, 2, 0, 2, 4'b0100);
        idle();
        step_sample(0, 0, 0, 1, 2);
        expect_msgs("R7 wb done", 1, 3, 0, 0, 0, 0, 0, 1, 2, 4'b1000);
        idle();
    endtask

    task automatic t_exc_wb();
        step_sample(0, 0, 0, 1, 3);
        expect_msgs("R8 owner wb", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        idle();
        step_sample(0, 0, 0, 1, 3);
        expect_msgs("R9 wb while uncached", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        idle();
    endtask

    task automatic t_unc_write();
        step_sample(1, 1, 2, 0, 0);
        expect_msgs("R3 unc write", 1, 2, 0, 0, 0, 0, 0, 0, 2, 4'b0100);
        idle();
    endtask

    task automatic t_collide();
        @(negedge clk);
        req_valid = 1'b1; req_is_wr = 1'b0; req_src = 2'd0;
        wb_valid = 1'b1; wb_src = 2'd2;
        #1;
        check("R10 ready low with wb", int'(req_ready), 0);
        @(posedge clk);
        #1;
        expect_msgs("R10 wb first", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        wb_valid = 1'b0;
        @(posedge clk);
        #1;
        expect_msgs("R10 held req taken", 1, 0, 0, 0, 0, 0, 0, 0, 1, 4'b0001);
        idle();
    endtask

    task automatic t_sole_sharer_write();
        step_sample(1, 1, 0, 0, 0);
        expect_msgs("R5 sole sharer no inv", 1, 0, 0, 0, 0, 0, 0, 0, 2, 4'b0001);
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_unc_read();
        t_shr_read();
        t_shr_write();
        t_ignored_wb();
        t_exc_read();
        t_shr_write2();
        t_exc_write();
        t_exc_wb();
        t_unc_write();
        t_collide();
        t_sole_sharer_write();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule